// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Compare Flags

The block is a memory-mapped timer. A free-running up-counter advances on pulses taken from one of several tick sources. A programmable prescaler divides those pulses first. Compare registers watch the counter and raise sticky flags. A single interrupt line reports any flag that software has enabled.

Software programs the block through a small single-cycle register bus. Flags are cleared by writing ones to the status register. A software reset clears the counting state but keeps the clock-selection and run-permission settings. Four state inputs stand for the stop, doze, wait and debug-halt conditions. Each can freeze the counter unless software has allowed counting in that state.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The word addresses are: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 to 6 compare channels 0 to 2, and 7 counter. Unmapped bits read zero.
- R2: The counter goes up by one on each advance and wraps from its all-ones value to zero without stopping.
- R3: With prescaler value p, the counter advances once every p+1 qualified source ticks. The divider phase starts at zero after a software reset.
- R4: Control bits [3:1] select the tick source. 0 is none. 1 is every clock cycle. 2 is `tick_hi`, 3 is `tick_ext`, 4 is `tick_slow` and 5 is `tick_fast`. Source 5 is used only while control bit 4 is set. Codes 6 and 7 give no ticks.
- R5: Control bit 0 enables counting. While it is clear, the counter holds its value.
- R6: Control bits 5, 6, 7 and 8 allow counting during `lp_stop`, `lp_doze`, `lp_wait` and `dbg_halt` respectively. An asserted state input whose allow bit is clear freezes the counter.
- R7: Status bit k is set at the same clock edge at which an advance makes the counter equal to compare channel k.
- R8: Writing status with a bit at 1 clears that flag. A bit written as 0 leaves its flag unchanged.
- R9: If a flag is set in the same cycle that a write clears it, the flag ends up set.
- R10: `irq` is high exactly when some status bit is set and its interrupt-enable bit is also set.
- R11: Writing 1 to control bit 15 starts a software reset. Bit 15 then reads 1 for exactly 4 cycles and then 0. The counter does not advance during this time.
- R12: When the software reset completes, the prescaler, status, interrupt-enable, compare and counter registers are zero and control bit 0 is clear. Control bits [8:1] keep their values.
- R13: The counter register is read-only, and writes to address 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| tick_hi | input | 1 | High-rate bus tick source |
| tick_ext | input | 1 | External tick source |
| tick_slow | input | 1 | Slow (32 kHz) tick source |
| tick_fast | input | 1 | 24 MHz tick source |
| lp_stop | input | 1 | Stop state indication |
| lp_doze | input | 1 | Doze state indication |
| lp_wait | input | 1 | Wait state indication |
| dbg_halt | input | 1 | Debug halt indication |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with CNT_W=8, PRE_W=4 and N_CMP=3. With an 8-bit counter, the wrap from 255 to 0 happens within about 300 cycles. The 4-bit prescaler lets the bench sweep all 16 divide ratios against the arithmetic value floor(ticks/(p+1)). The small configuration also makes a full cross of all eight source codes, each single active tick input and both settings of the fast-source enable cheap. The same applies to all four freeze inputs with their allow bits on and off. Flag timing is checked to the exact edge, and this includes a clear write that lands on the same cycle as a match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control register layout
    localparam int CTRL_BITS = 9;
    localparam int B_RUN     = 0;
    localparam int B_SEL_LO  = 1;
    localparam int SEL_W     = 3;
    localparam int B_FAST_EN = 4;
    localparam int B_OK_LO   = 5;   // four allow bits: stop, doze, wait, debug
    localparam int N_LP      = 4;
    localparam int B_SRST    = 15;

    // Bits that survive a software reset: source select, fast enable, allow bits
    localparam logic [CTRL_BITS-1:0] KEEP_MASK = 9'b1_1111_1110;

    localparam int SRST_CYCLES = 4;
    localparam int SR_W        = $clog2(SRST_CYCLES + 1);

    // Register word addresses
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_PRE  = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_IEN  = 3'd3;
    localparam logic [2:0] A_CMP0 = 3'd4;
    localparam logic [2:0] A_CNT  = 3'd7;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF    = 3'd0,
        SRC_BUS    = 3'd1,
        SRC_BUS_HI = 3'd2,
        SRC_EXT    = 3'd3,
        SRC_SLOW   = 3'd4,
        SRC_FAST   = 3'd5,
        SRC_RSV6   = 3'd6,
        SRC_RSV7   = 3'd7
    } src_e;

endpackage

// File: rtl/tmr_src_gate.sv
module tmr_src_gate
    import tmr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             fast_en,
    input  logic             tick_hi,
    input  logic             tick_ext,
    input  logic             tick_slow,
    input  logic             tick_fast,
    input  logic [N_LP-1:0]  lp_req,
    input  logic [N_LP-1:0]  lp_ok,
    input  logic             run,
    input  logic             busy,
    output logic             tick_ok
);
    logic src_tick;
    logic frozen;

    always_comb begin
        case (src_e'(sel))
            SRC_BUS:    src_tick = 1'b1;
            SRC_BUS_HI: src_tick = tick_hi;
            SRC_EXT:    src_tick = tick_ext;
            SRC_SLOW:   src_tick = tick_slow;
            SRC_FAST:   src_tick = tick_fast & fast_en;
            default:    src_tick = 1'b0;
        endcase
    end

    assign frozen  = |(lp_req & ~lp_ok);
    assign tick_ok = src_tick & run & ~busy & ~frozen;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [PRE_W-1:0] limit,
    output logic             adv
);
    logic [PRE_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        adv     = 1'b0;
        if (clear) begin
            phase_d = '0;
        end else if (tick) begin
            if (phase_q >= limit) begin
                phase_d = '0;
                adv     = 1'b1;
            end else begin
                phase_d = phase_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
    parameter int CNT_W = 32,
    parameter int N_CMP = 3
) (
    input  logic                   adv,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [N_CMP*CNT_W-1:0] cmp,
    output logic [N_CMP-1:0]       hit
);
    logic [CNT_W-1:0] cnt_next;

    assign cnt_next = cnt + 1'b1;

    for (genvar g = 0; g < N_CMP; g++) begin : g_chan
        assign hit[g] = adv && (cnt_next == cmp[g*CNT_W +: CNT_W]);
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 12,
    parameter int N_CMP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_hi,
    input  logic              tick_ext,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              lp_stop,
    input  logic              lp_doze,
    input  logic              lp_wait,
    input  logic              dbg_halt,
    output logic              irq
);
    typedef struct packed {
        logic [CTRL_BITS-1:0]   ctrl;
        logic [PRE_W-1:0]       pre;
        logic [N_CMP-1:0]       stat;
        logic [N_CMP-1:0]       ien;
        logic [N_CMP*CNT_W-1:0] cmp;
        logic [CNT_W-1:0]       cnt;
        logic [SR_W-1:0]        srst;
    } regs_t;

    regs_t r_d, r_q;

    logic             busy, done, run_q, wr_ok, tick_ok, adv;
    logic [N_CMP-1:0] hit, clr_vec;
    logic             unused_wbits;

    assign busy  = (r_q.srst != '0);
    assign done  = (r_q.srst == SR_W'(1));
    assign run_q = r_q.ctrl[B_RUN];
    assign wr_ok = bus_wr && !busy;   // non-control writes blocked during soft reset
    assign clr_vec = (wr_ok && bus_addr == A_STAT) ? bus_wdata[N_CMP-1:0] : '0;
    assign unused_wbits = ^bus_wdata;

    tmr_src_gate u_gate (
        .sel       (r_q.ctrl[B_SEL_LO +: SEL_W]),
        .fast_en   (r_q.ctrl[B_FAST_EN]),
        .tick_hi   (tick_hi),
        .tick_ext  (tick_ext),
        .tick_slow (tick_slow),
        .tick_fast (tick_fast),
        .lp_req    ({dbg_halt, lp_wait, lp_doze, lp_stop}),
        .lp_ok     (r_q.ctrl[B_OK_LO +: N_LP]),
        .run       (run_q),
        .busy      (busy),
        .tick_ok   (tick_ok)
    );

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_ok),
        .clear (done),
        .limit (r_q.pre),
        .adv   (adv)
    );

    tmr_match #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_match (
        .adv (adv),
        .cnt (r_q.cnt),
        .cmp (r_q.cmp),
        .hit (hit)
    );

    always_comb begin
        r_d = r_q;

        if (bus_wr && bus_addr == A_CTRL) begin
            r_d.ctrl = bus_wdata[CTRL_BITS-1:0];
            if (bus_wdata[B_SRST] && !busy) r_d.srst = SR_W'(SRST_CYCLES);
        end
        if (wr_ok && bus_addr == A_PRE) r_d.pre = bus_wdata[PRE_W-1:0];
        if (wr_ok && bus_addr == A_IEN) r_d.ien = bus_wdata[N_CMP-1:0];
        for (int k = 0; k < N_CMP; k++) begin
            if (wr_ok && bus_addr == 3'(A_CMP0 + k))
                r_d.cmp[k*CNT_W +: CNT_W] = bus_wdata[CNT_W-1:0];
        end

        // a new match outranks a simultaneous clear
        r_d.stat = (r_q.stat & ~clr_vec) | hit;

        if (adv)  r_d.cnt  = r_q.cnt + 1'b1;
        if (busy) r_d.srst = r_q.srst - 1'b1;

        if (done) begin
            r_d.ctrl = r_d.ctrl & KEEP_MASK;
            r_d.pre  = '0;
            r_d.stat = '0;
            r_d.ien  = '0;
            r_d.cmp  = '0;
            r_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CTRL_BITS-1:0] = r_q.ctrl;
                bus_rdata[B_SRST]        = busy;
            end
            A_PRE:  bus_rdata[PRE_W-1:0] = r_q.pre;
            A_STAT: bus_rdata[N_CMP-1:0] = r_q.stat;
            A_IEN:  bus_rdata[N_CMP-1:0] = r_q.ien;
            A_CNT:  bus_rdata[CNT_W-1:0] = r_q.cnt;
            default: ;
        endcase
        for (int k = 0; k < N_CMP; k++) begin
            if (bus_addr == 3'(A_CMP0 + k))
                bus_rdata[CNT_W-1:0] = r_q.cmp[k*CNT_W +: CNT_W];
        end
    end

    assign irq = |(r_q.stat & r_q.ien);

endmodule

// File: rtl/tmr_checks.sv
module tmr_checks #(
    parameter int CNT_W = 32,
    parameter int N_CMP = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [N_CMP-1:0] stat,
    input logic [N_CMP-1:0] ien,
    input logic [N_CMP-1:0] clr,
    input logic [N_CMP-1:0] hit
);
    // R2: counter moves by at most one step, with wrap
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !busy) |=> (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R5: stopped counter holds
    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !busy) |=> $stable(cnt));

    // R11: soft reset busy window is exactly four cycles
    p_busy_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy);

    // R11: no counting while busy
    p_frozen_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cnt));

    // R12: completion leaves cleared state
    p_srst_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt == '0 && stat == '0 && ien == '0 && !run));

    for (genvar g = 0; g < N_CMP; g++) begin : g_flag
        // R7 and R9: a match always lands in the flag
        p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> stat[g]);
        // R8: a flag only drops by a clear write or soft reset
        p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[g] && !clr[g] && !busy) |=> stat[g]);
    end

endmodule

bind tick_timer tmr_checks #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_checks (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .run   (run_q),
    .cnt   (r_q.cnt),
    .stat  (r_q.stat),
    .ien   (r_q.ien),
    .clr   (clr_vec),
    .hit   (hit)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int PRE_W  = 4;
    localparam int N_CMP  = 3;

    localparam logic [2:0] AD_CTRL = 3'd0, AD_PRE = 3'd1, AD_STAT = 3'd2,
                           AD_IEN = 3'd3, AD_CMP0 = 3'd4, AD_CNT = 3'd7;
    localparam logic [31:0] SEL_BUS = 32'h2;   // select code 1 in bits [3:1]

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic tick_hi = 0, tick_ext = 0, tick_slow = 0, tick_fast = 0;
    logic lp_stop = 0, lp_doze = 0, lp_wait = 0, dbg_halt = 0;
    logic irq;

    int checks = 0;
    int fails  = 0;

    tick_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .N_CMP(N_CMP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_hi(tick_hi), .tick_ext(tick_ext), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .lp_stop(lp_stop), .lp_doze(lp_doze), .lp_wait(lp_wait), .dbg_halt(dbg_halt),
        .irq(irq)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic srst(input logic [31:0] ctl, output int busy_n);
        logic [31:0] v;
        wr(AD_CTRL, ctl | 32'h8000);
        busy_n = 0;
        for (int n = 0; n < 10; n++) begin
            rd(AD_CTRL, v);
            if (v[15]) begin
                busy_n++;
                idle(1);
            end else begin
                break;
            end
        end
    endtask

    task automatic window(input logic [31:0] base, input int n, output logic [31:0] c);
        wr(AD_CTRL, base | 32'h1);
        idle(n);
        wr(AD_CTRL, base & ~32'h1);
        rd(AD_CNT, c);
    endtask

    initial begin
        logic [31:0] v, c1, c2;
        int bn;
        logic [31:0] base;
        int exp_c;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 addr %0d", a), v, 32'h0);
        end
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R3: prescaler sweep over all ratios
        for (int p = 0; p < 16; p++) begin
            srst(SEL_BUS, bn);
            wr(AD_PRE, p);
            window(SEL_BUS, 40, v);
            chk($sformatf("R3 prescale %0d", p), v, 32'(41 / (p + 1)));
        end

        // R4: every select code against each single active tick input
        for (int s = 0; s < 8; s++) begin
            for (int fe = 0; fe < 2; fe++) begin
                for (int j = 0; j < 4; j++) begin
                    base = 32'(s << 1) | 32'(fe << 4);
                    srst(base, bn);
                    tick_hi = (j == 0); tick_ext = (j == 1);
                    tick_slow = (j == 2); tick_fast = (j == 3);
                    window(base, 9, v);
                    tick_hi = 0; tick_ext = 0; tick_slow = 0; tick_fast = 0;
                    exp_c = ((s == 1) || (s == 2 && j == 0) || (s == 3 && j == 1) ||
                             (s == 4 && j == 2) || (s == 5 && j == 3 && fe == 1)) ? 10 : 0;
                    chk($sformatf("R4 sel %0d fast_en %0d input %0d", s, fe, j), v, 32'(exp_c));
                end
            end
        end

        // R6: freeze inputs with and without allow bits
        for (int j = 0; j < 4; j++) begin
            for (int ok = 0; ok < 2; ok++) begin
                base = SEL_BUS | 32'(ok << (5 + j));
                srst(base, bn);
                lp_stop = (j == 0); lp_doze = (j == 1); lp_wait = (j == 2); dbg_halt = (j == 3);
                window(base, 9, v);
                lp_stop = 0; lp_doze = 0; lp_wait = 0; dbg_halt = 0;
                chk($sformatf("R6 state %0d allow %0d", j, ok), v, (ok == 1) ? 32'd10 : 32'd0);
            end
        end

        // R2: wrap through all-ones
        srst(SEL_BUS, bn);
        window(SEL_BUS, 299, v);
        chk("R2 wrap", v, 32'(300 % 256));

        // R5: stopped counter holds
        idle(20);
        rd(AD_CNT, v);
        chk("R5 hold after stop", v, 32'd44);
        wr(AD_CTRL, 32'h0);
        idle(5);
        rd(AD_CNT, v);
        chk("R5 hold with control zero", v, 32'd44);

        // R13: counter is read-only
        wr(AD_CNT, 32'd99);
        rd(AD_CNT, v);
        chk("R13 counter write ignored", v, 32'd44);

        // R7: flag rises exactly at the matching value
        srst(SEL_BUS, bn);
        wr(AD_CMP0, 5);
        window(SEL_BUS, 3, v);
        rd(AD_STAT, c1);
        chk("R7 count 4 no flag", c1, 32'h0);
        srst(SEL_BUS, bn);
        wr(AD_CMP0, 5);
        window(SEL_BUS, 4, v);
        rd(AD_STAT, c1);
        chk("R7 count 5 flag", c1, 32'h1);

        // R7, R8, R10: several channels, enables and clears
        srst(SEL_BUS, bn);
        wr(AD_CMP0, 10);
        wr(AD_CMP0 + 3'd1, 20);
        wr(AD_CMP0 + 3'd2, 200);
        window(SEL_BUS, 24, v);
        chk("R2 count 25", v, 32'd25);
        rd(AD_STAT, v);
        chk("R7 two channels matched", v, 32'h3);
        chk("R10 no enable no irq", {31'h0, irq}, 32'h0);
        wr(AD_IEN, 32'h4);
        chk("R10 enable on idle channel", {31'h0, irq}, 32'h0);
        wr(AD_IEN, 32'h2);
        chk("R10 enable on pending channel", {31'h0, irq}, 32'h1);
        wr(AD_STAT, 32'h2);
        rd(AD_STAT, v);
        chk("R8 clear one flag", v, 32'h1);
        chk("R10 irq drops after clear", {31'h0, irq}, 32'h0);
        wr(AD_STAT, 32'h0);
        rd(AD_STAT, v);
        chk("R8 zero write keeps flag", v, 32'h1);
        wr(AD_STAT, 32'h1);
        rd(AD_STAT, v);
        chk("R8 clear last flag", v, 32'h0);

        // R9: clear write lands on the match edge
        srst(SEL_BUS, bn);
        wr(AD_CMP0, 4);
        wr(AD_CTRL, SEL_BUS | 32'h1);
        idle(3);
        wr(AD_STAT, 32'h1);
        wr(AD_CTRL, SEL_BUS);
        rd(AD_STAT, v);
        chk("R9 set wins over clear", v, 32'h1);
        srst(SEL_BUS, bn);
        wr(AD_CMP0, 4);
        wr(AD_CTRL, SEL_BUS | 32'h1);
        idle(4);
        wr(AD_STAT, 32'h1);
        wr(AD_CTRL, SEL_BUS);
        rd(AD_STAT, v);
        chk("R8 clear one cycle after match", v, 32'h0);

        // R11, R12: soft reset while running with everything set
        srst(SEL_BUS, bn);
        chk("R11 busy length", bn, 32'd4);
        wr(AD_CTRL, 32'h1F3);
        wr(AD_IEN, 32'h7);
        wr(AD_CMP0, 3);
        wr(AD_CMP0 + 3'd1, 7);
        wr(AD_CMP0 + 3'd2, 9);
        idle(20);
        chk("R10 irq before soft reset", {31'h0, irq}, 32'h1);
        wr(AD_PRE, 32'h0);
        wr(AD_CTRL, 32'h81F3);
        rd(AD_CNT, c1);
        idle(3);
        rd(AD_CNT, c2);
        chk("R11 counter frozen while busy", c2, c1);
        rd(AD_CTRL, v);
        chk("R11 busy bit in last cycle", {31'h0, v[15]}, 32'h1);
        idle(1);
        rd(AD_CTRL, v);
        chk("R12 control keeps [8:1]", v, 32'h1F2);
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R12 addr %0d cleared", a), v, 32'h0);
        end
        chk("R12 irq low", {31'h0, irq}, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule